// File: doc/BRIEF.md
# Rotating Unit-Element Selector for a Segmented Capacitor DAC

This block is the digital control logic placed in front of a segmented switched-capacitor digital-to-analog converter. Each accepted sample is split into an upper and a lower segment. The upper segment picks how many of the equally weighted unit elements take part in the conversion. The lower segment is registered and driven straight onto binary-weighted switch controls.

With rotation off, a code of k always uses the first k elements. With rotation on, a pointer chooses where the k elements start. The pointer moves on by k after every conversion. Over many conversions this spreads element mismatch evenly across the whole array instead of fixing it to particular codes.

Every conversion runs a fixed four-cycle sequence: a dead cycle in which the controls load, a charge phase, a second dead cycle, and a transfer phase. A feedback-reset strobe is raised during the charge phase when it was requested together with the sample. A sleep input stops new conversions, and while it is set every phase output stays low.

Top module: `dwa_seg_dac_front`

## Requirements
- R1: A sample `in_code` of MSB_W+LSB_W bits splits into an upper value k = in_code[11:6] and a lower value `in_code[5:0]`. The lower value appears on `lsb_ctl`. It changes in the same clock edge as the `elem_ctl` of the same sample.
- R2: With `rot_en` low at acceptance, `elem_ctl` bits 0 through k-1 are set and all other bits are clear.
- R3: With `rot_en` high at acceptance, `elem_ctl` holds k set bits. They start at the pointer and run upward, wrapping from bit 62 to bit 0. The pointer then becomes (pointer + k) mod 63. The pointer is 0 after reset and does not move on conversions taken with rotation off.
- R4: An upper value of 0 sets no element bit and leaves the pointer unchanged. An upper value of 63 sets all 63 bits.
- R5: With rotation on, a run of conversions whose upper values sum to a multiple of 63 uses every element the same number of times.
- R6: An accepted sample gives one charge cycle (`phi_chg`), then one dead cycle, then one transfer cycle (`phi_xfer`), then one dead load cycle. The two phases are never high together.
- R7: `elem_ctl` and `lsb_ctl` change only at the edge that ends a load cycle in which a sample was accepted.
- R8: `fb_rst` is high exactly during the charge cycle of a conversion whose `fb_rst_en` was high at acceptance.
- R9: While `sleep` is high in the load cycle, no sample is taken, `in_ready` is low, both phases stay low and the controls hold.
- R10: After reset, `elem_ctl`, `lsb_ctl`, `phi_chg`, `phi_xfer` and `fb_rst` are zero, and `in_ready` is high unless `sleep` is set.
- R11: `in_ready` is high only in the load cycle. A sample is accepted at a clock edge where `in_valid` and `in_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Stops new conversions and all switching |
| rot_en | input | 1 | Rotation enable, sampled with each sample |
| fb_rst_en | input | 1 | Feedback reset request, sampled with each sample |
| in_valid | input | 1 | Sample valid |
| in_code | input | 12 | Sample code, upper segment in the high bits |
| in_ready | output | 1 | Block can take a sample this cycle |
| elem_ctl | output | 63 | Unit-element reference steering, one bit per element |
| lsb_ctl | output | 6 | Binary-weighted lower-segment switch controls |
| phi_chg | output | 1 | Charge phase |
| phi_xfer | output | 1 | Charge-sharing transfer phase |
| fb_rst | output | 1 | Feedback element discharge |

## Verification
The hardest case to reach is the pointer wrapping past element 62 while a large code is in flight. A second hard case is a run in which every element has been used the same number of times. The stimulus uses chains of rotated codes whose upper values add up to whole multiples of 63, including codes of 63, codes of 0 and mixed runs, so the pointer crosses the wrap point several times. A behavioural model tracks the pointer and the phase sequence and is compared on every clock. Separate phases then hold sleep high against a pending sample, toggle rotation off in the middle of a run, and alternate the feedback-reset request.

// File: rtl/dwa_seg_dac_front.sv
module dwa_seg_dac_front #(
  parameter int MSB_W = 6,
  parameter int LSB_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sleep,
  input  logic                         rot_en,
  input  logic                         fb_rst_en,
  input  logic                         in_valid,
  input  logic [MSB_W+LSB_W-1:0]       in_code,
  output logic                         in_ready,
  output logic [(1<<MSB_W)-2:0]        elem_ctl,
  output logic [LSB_W-1:0]             lsb_ctl,
  output logic                         phi_chg,
  output logic                         phi_xfer,
  output logic                         fb_rst
);
  localparam int NEL = (1 << MSB_W) - 1;

  typedef enum logic [1:0] {ST_LOAD, ST_CHG, ST_GAP, ST_XFER} st_t;

  st_t              st;
  logic [MSB_W-1:0] ptr, k_q;
  logic             rst_q;

  logic [MSB_W-1:0] k;
  logic [NEL-1:0]   ones, rotd, sel;
  logic [MSB_W:0]   sum;
  logic [MSB_W-1:0] ptr_nxt;
  logic             take;

  assign k        = in_code[MSB_W+LSB_W-1:LSB_W];
  assign ones     = {NEL{1'b1}} >> (NEL - int'(k));
  assign rotd     = (ones << ptr) | (ones >> (NEL - int'(ptr)));
  assign sel      = rot_en ? rotd : ones;
  assign sum      = {1'b0, ptr} + {1'b0, k};
  assign ptr_nxt  = (int'(sum) >= NEL) ? MSB_W'(int'(sum) - NEL) : sum[MSB_W-1:0];

  assign in_ready = (st == ST_LOAD) && !sleep;
  assign take     = in_ready && in_valid;
  assign phi_chg  = (st == ST_CHG);
  assign phi_xfer = (st == ST_XFER);
  assign fb_rst   = phi_chg && rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_LOAD;
      ptr      <= '0;
      k_q      <= '0;
      rst_q    <= 1'b0;
      elem_ctl <= '0;
      lsb_ctl  <= '0;
    end else begin
      case (st)
        ST_LOAD: if (take) begin
          elem_ctl <= sel;
          lsb_ctl  <= in_code[LSB_W-1:0];
          k_q      <= k;
          rst_q    <= fb_rst_en;
          if (rot_en) ptr <= ptr_nxt;
          st       <= ST_CHG;
        end
        ST_CHG:  st <= ST_GAP;
        ST_GAP:  st <= ST_XFER;
        default: st <= ST_LOAD;
      endcase
    end
  end

  // R6
  phase_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi_chg && phi_xfer));

  // R6
  xfer_after_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phi_chg |=> (!phi_chg && !phi_xfer));

  // R7
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(elem_ctl) && $stable(lsb_ctl)));

  // R1
  elem_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phi_chg |-> ($countones(elem_ctl) == int'(k_q)));

  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < NEL);

  // R9
  sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && st == ST_LOAD) |=> (!phi_chg && !phi_xfer));
endmodule

// File: tb/dwa_seg_dac_front_tb_top.sv
module dwa_seg_dac_front_tb_top;
  localparam int NEL = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep = 1'b0, rot_en = 1'b0, fb_rst_en = 1'b0, in_valid = 1'b0;
  logic [11:0] in_code = '0;
  logic in_ready, phi_chg, phi_xfer, fb_rst;
  logic [NEL-1:0] elem_ctl;
  logic [5:0] lsb_ctl;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R2";

  int mst = 0, mptr = 0;
  logic [NEL-1:0] m_elem = '0;
  logic [5:0] m_lsb = '0;
  logic m_rst = 1'b0;
  int use_cnt [NEL];
  logic done = 1'b0;

  always #5 clk = ~clk;

  dwa_seg_dac_front dut_i (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .rot_en(rot_en),
    .fb_rst_en(fb_rst_en), .in_valid(in_valid), .in_code(in_code),
    .in_ready(in_ready), .elem_ctl(elem_ctl), .lsb_ctl(lsb_ctl),
    .phi_chg(phi_chg), .phi_xfer(phi_xfer), .fb_rst(fb_rst));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [NEL-1:0] act, input logic [NEL-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      mst = 0; mptr = 0; m_elem = '0; m_lsb = '0; m_rst = 1'b0;
    end else begin
      chk(elem_ctl === m_elem, {"R2/R3 ", cur_req}, "elem_ctl", elem_ctl, m_elem);
      chk(lsb_ctl === m_lsb, "R1 R7", "lsb_ctl", NEL'(lsb_ctl), NEL'(m_lsb));
      chk(phi_chg === (mst == 1) && phi_xfer === (mst == 3), "R6", "phases",
          NEL'({phi_chg, phi_xfer}), NEL'({mst == 1, mst == 3}));
      chk(fb_rst === (mst == 1 && m_rst), "R8", "fb_rst", NEL'(fb_rst), NEL'(mst == 1 && m_rst));
      chk(in_ready === (mst == 0 && !sleep), "R11", "in_ready", NEL'(in_ready), NEL'(mst == 0 && !sleep));
      if (phi_chg)
        for (int i = 0; i < NEL; i++) use_cnt[i] += int'(elem_ctl[i]);
      if (mst == 0) begin
        if (in_valid && !sleep) begin
          int k;
          k = int'(in_code[11:6]);
          m_elem = '0;
          for (int j = 0; j < k; j++) m_elem[rot_en ? (mptr + j) % NEL : j] = 1'b1;
          if (rot_en) mptr = (mptr + k) % NEL;
          m_lsb = in_code[5:0];
          m_rst = fb_rst_en;
          mst = 1;
        end
      end else mst = (mst + 1) % 4;
    end
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic conv(input int k, input int lo, input bit rot, input bit fr);
    @(posedge clk); #2;
    in_valid = 1'b1; in_code = {6'(k), 6'(lo)}; rot_en = rot; fb_rst_en = fr;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NEL; i++) use_cnt[i] = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(elem_ctl == '0 && lsb_ctl == '0 && !phi_chg && !phi_xfer && !fb_rst && in_ready,
        "R10", "reset outputs", elem_ctl, '0);

    cur_req = "R2";
    conv(3, 5, 0, 0); conv(63, 63, 0, 1); conv(17, 0, 0, 0); conv(1, 42, 0, 1);

    cur_req = "R4";
    conv(0, 9, 1, 0); conv(63, 1, 1, 0); conv(0, 2, 1, 1);

    cur_req = "R3";
    conv(10, 3, 1, 0); conv(60, 7, 1, 1); conv(45, 11, 1, 0); conv(62, 0, 1, 0);
    conv(7, 8, 0, 0); conv(30, 31, 1, 1);
    repeat (4) @(posedge clk);

    // R5 equal use: upper values sum to 3*63 after a clean restart
    cur_req = "R5";
    @(posedge clk); #2 rst_n = 1'b0;
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NEL; i++) use_cnt[i] = 0;
    conv(5, 1, 1, 0); conv(17, 2, 1, 0); conv(41, 3, 1, 0);
    conv(63, 4, 1, 1); conv(20, 5, 1, 0); conv(0, 6, 1, 0); conv(43, 7, 1, 0);
    repeat (5) @(negedge clk);
    begin
      bit eq;
      eq = 1'b1;
      for (int i = 0; i < NEL; i++) if (use_cnt[i] != 3) eq = 1'b0;
      chk(eq, "R5", "every element used three times", NEL'(use_cnt[0]), NEL'(3));
    end

    // R9 sleep blocks a pending sample
    cur_req = "R9";
    begin
      logic [NEL-1:0] held;
      @(posedge clk); #2;
      sleep = 1'b1; in_valid = 1'b1; in_code = {6'd22, 6'd13}; rot_en = 1'b1;
      held = elem_ctl;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        chk(!phi_chg && !phi_xfer && !in_ready && elem_ctl == held, "R9",
            "sleep hold", elem_ctl, held);
      end
      @(posedge clk); #2 sleep = 1'b0;
      @(posedge clk); #2 in_valid = 1'b0;
      repeat (6) @(negedge clk);
    end

    cur_req = "R7";
    conv(9, 60, 1, 1); conv(55, 33, 1, 0);
    repeat (6) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule